// File: doc/BRIEF.md
# Power Mode Sequencer

The block moves a processor subsystem between a running state and three
progressively deeper low-power states. It produces the enable for the CPU clock
gate and the power enables for the CPU logic, the SRAM, the peripheral blocks
and an always-on domain that holds the brown-out detector and the watchdog. The
switches and regulators behind these enables are outside the block.

Software asks for a low-power state with a one-cycle request pulse and a 2-bit
state code. An entry phase gates the CPU clock first. After a fixed number of
cycles the chosen state's power pattern is applied. A peripheral interrupt or
an external wake pin ends the low-power state. Return then goes through an exit
phase. In this phase every power enable is back on and the clock stays gated
for a wake-up time. That time comes from a 16-bit base value: it is used as is
for sleep, scaled by eight for deep sleep, and scaled by eighty for power-off.
Leaving power-off also holds a system reset for the whole exit phase, so the
subsystem restarts from scratch rather than resuming.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_n` is low and after its release, all five enables read 1, `mode_status` reads 00 and `sys_reset_out` reads 0 until a request is accepted.
- R2: A request pulse in the running state with code 01 (sleep), 10 (deep sleep) or 11 (power-off) is accepted at that clock edge. From the next cycle `mode_status` shows the code and the CPU clock enable is 0 while the four power enables stay 1. This entry phase lasts ENTRY_CYCLES (default 2) cycles.
- R3: After entry, the enables in the order clock, CPU, SRAM, peripheral, always-on read 01111 for sleep, 01101 for deep sleep and 00000 for power-off.
- R4: The interrupt wake input ends sleep and deep sleep but has no effect in power-off. The wake pin ends any low-power state. A wake sampled at a clock edge starts the exit phase from the next cycle.
- R5: During the exit phase the clock enable is 0, the CPU, SRAM and peripheral power enables are 1 and `mode_status` keeps the code. The phase lasts L cycles, then the running pattern returns with status 00. L is the base value for sleep, 8 times the base for deep sleep and 80 times the base for power-off. A base of 0 gives L = 1.
- R6: `sys_reset_out` is 1 exactly during the exit phase from power-off and is 0 everywhere else.
- R7: A wake that is valid for the requested state and is sampled in the same cycle as the request, or during the entry phase, is kept. The exit phase then starts directly after entry, and the state's own power pattern is never shown.
- R8: A request with code 00, or any request while not in the running state, changes neither the enables nor `mode_status`.
- R9: The wake-up counter holds 80 times the largest base value without wrapping, and it counts strictly down through the exit phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_req | input | 1 | One-cycle low-power request from software |
| lp_code | input | 2 | Requested state: 01 sleep, 10 deep sleep, 11 power-off |
| wake_base | input | 16 | Base wake-up time in cycles (sleep value) |
| wake_irq | input | 1 | Peripheral interrupt wake |
| wake_pin | input | 1 | External wake event, valid in every state |
| en_cpu_clk | output | 1 | CPU clock gate enable |
| en_cpu_pwr | output | 1 | CPU logic power enable |
| en_sram_pwr | output | 1 | SRAM power enable |
| en_periph_pwr | output | 1 | Peripheral power enable |
| en_aon_pwr | output | 1 | Always-on domain (brown-out, watchdog) power enable |
| sys_reset_out | output | 1 | System reset held while returning from power-off |
| mode_status | output | 2 | Current or target state: 00 run, 01 sleep, 10 deep sleep, 11 power-off |

## Verification
Two things can land on the same clock edge: the acceptance of a request and a wake event, or the last entry cycle and a wake event. The bench raises the interrupt in the request cycle, in the middle of entry and on the final entry edge. In each case it expects the exit pattern on the cycle right after entry and never the sleep pattern. The bench also raises the interrupt and a second request together with a low-power state that must ignore them. It judges each case by the enable vector and status it sampled cycle by cycle.

// File: rtl/pms_pkg.sv
package pms_pkg;

   typedef enum logic [1:0] {
      PM_RUN   = 2'b00,
      PM_SLEEP = 2'b01,
      PM_DEEP  = 2'b10,
      PM_OFF   = 2'b11
   } pm_mode_e;

   typedef enum logic [1:0] {
      ST_RUN,
      ST_ENTER,
      ST_LOW,
      ST_EXIT
   } pm_state_e;

   typedef struct packed {
      logic cpu_clk;
      logic cpu_pwr;
      logic sram_pwr;
      logic periph_pwr;
      logic aon_pwr;
   } dom_en_t;

   localparam dom_en_t DOM_ALL_ON   = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
   localparam dom_en_t DOM_CLK_GATE = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
   localparam dom_en_t DOM_DEEP     = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
   localparam dom_en_t DOM_ALL_OFF  = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

endpackage

// File: rtl/pms_latency.sv
module pms_latency
   import pms_pkg::*;
#(
   parameter int BASE_W     = 16,
   parameter int DEEP_RATIO = 8,
   parameter int OFF_RATIO  = 10,
   parameter int LAT_W      = 23
) (
   input  logic [BASE_W-1:0] base_cyc,
   input  pm_mode_e          mode,
   output logic [LAT_W-1:0]  lat_cyc
);

   localparam int DEEP_SH   = $clog2(DEEP_RATIO);
   localparam int OFF_SH    = $clog2(OFF_RATIO);
   localparam bit DEEP_POW2 = (DEEP_RATIO == (1 << DEEP_SH));
   localparam bit OFF_POW2  = (OFF_RATIO == (1 << OFF_SH));
   localparam int NEED_W    = BASE_W + $clog2(DEEP_RATIO * OFF_RATIO + 1);

   if (DEEP_RATIO < 1 || OFF_RATIO < 1) begin : g_bad_ratio
      $error("pms_latency: ratios must be at least 1");
   end
   if (LAT_W < NEED_W) begin : g_bad_width
      $error("pms_latency: LAT_W too narrow for the scaled latency");
   end

   logic [LAT_W-1:0] base_ext;
   logic [LAT_W-1:0] deep_lat;
   logic [LAT_W-1:0] off_lat;
   logic [LAT_W-1:0] raw_lat;

   assign base_ext = LAT_W'(base_cyc);

   if (DEEP_POW2) begin : g_deep_shift
      assign deep_lat = base_ext << DEEP_SH;
   end else begin : g_deep_mul
      assign deep_lat = base_ext * LAT_W'(DEEP_RATIO);
   end

   if (OFF_POW2) begin : g_off_shift
      assign off_lat = deep_lat << OFF_SH;
   end else begin : g_off_mul
      assign off_lat = deep_lat * LAT_W'(OFF_RATIO);
   end

   always_comb begin
      unique case (mode)
         PM_DEEP: raw_lat = deep_lat;
         PM_OFF:  raw_lat = off_lat;
         default: raw_lat = base_ext;
      endcase
      lat_cyc = (raw_lat == '0) ? LAT_W'(1) : raw_lat;
   end

endmodule

// File: rtl/pms_wake_timer.sv
module pms_wake_timer #(
   parameter int LAT_W = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LAT_W-1:0] lat_cyc,
   input  logic             dec,
   output logic             done,
   output logic [LAT_W-1:0] cnt
);

   logic [LAT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= lat_cyc;
      end else if (dec && cnt_q > LAT_W'(1)) begin
         cnt_q <= cnt_q - LAT_W'(1);
      end
   end

   assign done = (cnt_q == LAT_W'(1));
   assign cnt  = cnt_q;

endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
   import pms_pkg::*;
#(
   parameter int ENTRY_CYCLES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req,
   input  pm_mode_e  req_mode,
   input  logic      wake_irq,
   input  logic      wake_pin,
   input  logic      timer_done,
   output pm_state_e state,
   output pm_mode_e  mode,
   output logic      load_timer
);

   localparam int ENT_W = $clog2(ENTRY_CYCLES + 1);

   if (ENTRY_CYCLES < 1) begin : g_bad_entry
      $error("pms_fsm: ENTRY_CYCLES must be at least 1");
   end

   pm_state_e        st_q, st_d;
   pm_mode_e         mode_q, mode_d;
   logic [ENT_W-1:0] ent_q, ent_d;
   logic             pend_q, pend_d;
   logic             wake_for_tgt;
   logic             wake_for_req;
   logic             req_ok;

   assign wake_for_tgt = wake_pin || (wake_irq && mode_q != PM_OFF);
   assign wake_for_req = wake_pin || (wake_irq && req_mode != PM_OFF);
   assign req_ok       = req && (req_mode != PM_RUN);

   always_comb begin
      st_d       = st_q;
      mode_d     = mode_q;
      ent_d      = ent_q;
      pend_d     = pend_q;
      load_timer = 1'b0;
      unique case (st_q)
         ST_RUN: begin
            if (req_ok) begin
               st_d   = ST_ENTER;
               mode_d = req_mode;
               ent_d  = ENT_W'(ENTRY_CYCLES);
               pend_d = wake_for_req;
            end
         end
         ST_ENTER: begin
            if (ent_q == ENT_W'(1)) begin
               pend_d = 1'b0;
               if (pend_q || wake_for_tgt) begin
                  st_d       = ST_EXIT;
                  load_timer = 1'b1;
               end else begin
                  st_d = ST_LOW;
               end
            end else begin
               ent_d  = ent_q - ENT_W'(1);
               pend_d = pend_q || wake_for_tgt;
            end
         end
         ST_LOW: begin
            if (wake_for_tgt) begin
               st_d       = ST_EXIT;
               load_timer = 1'b1;
            end
         end
         ST_EXIT: begin
            if (timer_done) begin
               st_d   = ST_RUN;
               mode_d = PM_RUN;
            end
         end
         default: st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_RUN;
         mode_q <= PM_RUN;
         ent_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         mode_q <= mode_d;
         ent_q  <= ent_d;
         pend_q <= pend_d;
      end
   end

   assign state = st_q;
   assign mode  = mode_q;

endmodule

// File: rtl/pms_domain_map.sv
module pms_domain_map
   import pms_pkg::*;
(
   input  pm_state_e state,
   input  pm_mode_e  mode,
   output dom_en_t   dom,
   output logic      sys_rst
);

   always_comb begin
      sys_rst = 1'b0;
      unique case (state)
         ST_RUN:   dom = DOM_ALL_ON;
         ST_ENTER: dom = DOM_CLK_GATE;
         ST_EXIT: begin
            dom     = DOM_CLK_GATE;
            sys_rst = (mode == PM_OFF);
         end
         ST_LOW: begin
            unique case (mode)
               PM_SLEEP: dom = DOM_CLK_GATE;
               PM_DEEP:  dom = DOM_DEEP;
               PM_OFF:   dom = DOM_ALL_OFF;
               default:  dom = DOM_ALL_ON;
            endcase
         end
         default: dom = DOM_ALL_ON;
      endcase
   end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pms_pkg::*;
#(
   parameter int BASE_W       = 16,
   parameter int DEEP_RATIO   = 8,
   parameter int OFF_RATIO    = 10,
   parameter int ENTRY_CYCLES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lp_req,
   input  logic [1:0]        lp_code,
   input  logic [BASE_W-1:0] wake_base,
   input  logic              wake_irq,
   input  logic              wake_pin,
   output logic              en_cpu_clk,
   output logic              en_cpu_pwr,
   output logic              en_sram_pwr,
   output logic              en_periph_pwr,
   output logic              en_aon_pwr,
   output logic              sys_reset_out,
   output logic [1:0]        mode_status
);

   localparam int LAT_W = BASE_W + $clog2(DEEP_RATIO * OFF_RATIO + 1);

   pm_state_e        state;
   pm_mode_e         mode;
   logic             load_timer;
   logic             timer_done;
   logic [LAT_W-1:0] lat_cyc;
   logic [LAT_W-1:0] lat_cnt;
   dom_en_t          dom;

   pms_fsm #(
      .ENTRY_CYCLES (ENTRY_CYCLES)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (lp_req),
      .req_mode   (pm_mode_e'(lp_code)),
      .wake_irq   (wake_irq),
      .wake_pin   (wake_pin),
      .timer_done (timer_done),
      .state      (state),
      .mode       (mode),
      .load_timer (load_timer)
   );

   pms_latency #(
      .BASE_W     (BASE_W),
      .DEEP_RATIO (DEEP_RATIO),
      .OFF_RATIO  (OFF_RATIO),
      .LAT_W      (LAT_W)
   ) u_lat (
      .base_cyc (wake_base),
      .mode     (mode),
      .lat_cyc  (lat_cyc)
   );

   pms_wake_timer #(
      .LAT_W (LAT_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_timer),
      .lat_cyc (lat_cyc),
      .dec     (state == ST_EXIT),
      .done    (timer_done),
      .cnt     (lat_cnt)
   );

   pms_domain_map u_map (
      .state   (state),
      .mode    (mode),
      .dom     (dom),
      .sys_rst (sys_reset_out)
   );

   assign en_cpu_clk    = dom.cpu_clk;
   assign en_cpu_pwr    = dom.cpu_pwr;
   assign en_sram_pwr   = dom.sram_pwr;
   assign en_periph_pwr = dom.periph_pwr;
   assign en_aon_pwr    = dom.aon_pwr;
   assign mode_status   = mode;

endmodule

// File: rtl/pms_checker.sv
module pms_checker
   import pms_pkg::*;
#(
   parameter int LAT_W = 23
) (
   input logic             clk,
   input logic             rst_n,
   input pm_state_e        state,
   input logic [LAT_W-1:0] lat_cnt,
   input logic             wake_pin,
   input logic             en_cpu_clk,
   input logic             en_cpu_pwr,
   input logic             en_sram_pwr,
   input logic             en_periph_pwr,
   input logic             sys_reset_out,
   input logic [1:0]       mode_status
);

   // R2: any non-run status keeps the CPU clock gated
   a_r2_clk_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_status != 2'b00) |-> !en_cpu_clk);

   // R4: interrupt alone never ends power-off
   a_r4_irq_no_off_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOW && mode_status == 2'b11 && !wake_pin) |=> (state == ST_LOW));

   // R5: exit phase restores power with the clock still gated
   a_r5_exit_powered: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXIT) |-> (en_cpu_pwr && en_sram_pwr && en_periph_pwr && !en_cpu_clk));

   // R6: system reset only while returning from power-off
   a_r6_reset_only_off: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset_out |-> (mode_status == 2'b11 && state == ST_EXIT));

   // R8: a target, once taken, is not replaced before returning to run
   a_r8_target_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_status != 2'b00 && $past(mode_status) != 2'b00) |-> $stable(mode_status));

   // R9: counter never wraps and counts down through exit
   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXIT && $past(state) == ST_EXIT) |-> (lat_cnt < $past(lat_cnt)));

   a_r9_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXIT) |-> (lat_cnt != '0));

endmodule

bind pwr_mode_seq pms_checker #(
   .LAT_W (LAT_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .state         (state),
   .lat_cnt       (lat_cnt),
   .wake_pin      (wake_pin),
   .en_cpu_clk    (en_cpu_clk),
   .en_cpu_pwr    (en_cpu_pwr),
   .en_sram_pwr   (en_sram_pwr),
   .en_periph_pwr (en_periph_pwr),
   .sys_reset_out (sys_reset_out),
   .mode_status   (mode_status)
);

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;

   localparam logic [4:0] V_RUN  = 5'b11111;
   localparam logic [4:0] V_GATE = 5'b01111;
   localparam logic [4:0] V_DEEP = 5'b01101;
   localparam logic [4:0] V_OFF  = 5'b00000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lp_req = 1'b0;
   logic [1:0]  lp_code = 2'b00;
   logic [15:0] wake_base = 16'd3;
   logic        wake_irq = 1'b0;
   logic        wake_pin = 1'b0;
   logic        en_cpu_clk, en_cpu_pwr, en_sram_pwr, en_periph_pwr, en_aon_pwr;
   logic        sys_reset_out;
   logic [1:0]  mode_status;

   int cyc = 0;
   int n_cmp = 0;
   int n_bad = 0;

   typedef struct {
      int         at;
      logic [4:0] en;
      logic [1:0] st;
      logic       rs;
      string      tag;
   } exp_t;

   exp_t q[$];
   exp_t e;

   always #5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   pwr_mode_seq u_pwr_mode_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .lp_req        (lp_req),
      .lp_code       (lp_code),
      .wake_base     (wake_base),
      .wake_irq      (wake_irq),
      .wake_pin      (wake_pin),
      .en_cpu_clk    (en_cpu_clk),
      .en_cpu_pwr    (en_cpu_pwr),
      .en_sram_pwr   (en_sram_pwr),
      .en_periph_pwr (en_periph_pwr),
      .en_aon_pwr    (en_aon_pwr),
      .sys_reset_out (sys_reset_out),
      .mode_status   (mode_status)
   );

   // monitor: compares the scoreboard head against outputs 1 ns after each edge
   always @(posedge clk) begin
      #1;
      while (q.size() > 0 && q[0].at <= cyc) begin
         e = q.pop_front();
         n_cmp++;
         if (q.size() >= 0 && ({en_cpu_clk, en_cpu_pwr, en_sram_pwr, en_periph_pwr, en_aon_pwr} !== e.en
             || mode_status !== e.st || sys_reset_out !== e.rs)) begin
            n_bad++;
            $display("FAIL %s @%0d: got en=%b st=%b rs=%b expected en=%b st=%b rs=%b",
               e.tag, cyc, {en_cpu_clk, en_cpu_pwr, en_sram_pwr, en_periph_pwr, en_aon_pwr},
               mode_status, sys_reset_out, e.en, e.st, e.rs);
         end
      end
   end

   task automatic push_exp(int at, logic [4:0] en, logic [1:0] st, logic rs, string tag);
      exp_t x;
      x.at = at; x.en = en; x.st = st; x.rs = rs; x.tag = tag;
      q.push_back(x);
   endtask

   // full low-power round trip with a wake in the low state
   task automatic round_trip(logic [1:0] code, bit use_pin, int lat, string tg);
      int c = cyc;
      logic [4:0] lowv = (code == 2'b01) ? V_GATE : (code == 2'b10) ? V_DEEP : V_OFF;
      logic [1:0] alt  = (code == 2'b11) ? 2'b01 : 2'b11;
      logic       rs   = (code == 2'b11);
      push_exp(c + 1, V_GATE, code, 1'b0, {"R2 entry ", tg});
      push_exp(c + 2, V_GATE, code, 1'b0, {"R2 entry end ", tg});
      push_exp(c + 3, lowv, code, 1'b0, {"R3 pattern ", tg});
      push_exp(c + 4, lowv, code, 1'b0, {"R4 irq ignored ", tg});
      push_exp(c + 5, lowv, code, 1'b0, {"R8 request ignored ", tg});
      push_exp(c + 6, V_GATE, code, rs, {"R5 R6 exit start ", tg});
      if (lat > 1) push_exp(c + 5 + lat, V_GATE, code, rs, {"R5 R6 exit last ", tg});
      push_exp(c + 6 + lat, V_RUN, 2'b00, 1'b0, {"R5 R9 back to run ", tg});
      lp_req = 1'b1; lp_code = code;
      @(negedge clk); lp_req = 1'b0; lp_code = 2'b00;
      @(negedge clk);
      @(negedge clk); if (code == 2'b11) wake_irq = 1'b1;
      @(negedge clk); wake_irq = 1'b0; lp_req = 1'b1; lp_code = alt;
      @(negedge clk); lp_req = 1'b0; lp_code = 2'b00;
      if (use_pin) wake_pin = 1'b1; else wake_irq = 1'b1;
      @(negedge clk); wake_pin = 1'b0; wake_irq = 1'b0;
      repeat (lat) @(negedge clk);
   endtask

   // sleep request with an interrupt sampled at edge c+wedge (1..3)
   task automatic latched_wake(int wedge, int lat, string tg);
      int c = cyc;
      push_exp(c + 1, V_GATE, 2'b01, 1'b0, {"R7 entry ", tg});
      push_exp(c + 3, V_GATE, 2'b01, 1'b0, {"R7 no sleep pattern ", tg});
      push_exp(c + 3 + lat, V_RUN, 2'b00, 1'b0, {"R7 R5 run ", tg});
      lp_req = 1'b1; lp_code = 2'b01;
      if (wedge == 1) wake_irq = 1'b1;
      @(negedge clk); lp_req = 1'b0; lp_code = 2'b00; wake_irq = (wedge == 2);
      @(negedge clk); wake_irq = (wedge == 3);
      @(negedge clk); wake_irq = 1'b0;
      repeat (lat + 1) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      push_exp(cyc + 1, V_RUN, 2'b00, 1'b0, "R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      push_exp(cyc + 1, V_RUN, 2'b00, 1'b0, "R1 after release");
      push_exp(cyc + 2, V_RUN, 2'b00, 1'b0, "R1 idle");
      repeat (2) @(negedge clk);

      // R8: code 00 request has no effect
      push_exp(cyc + 1, V_RUN, 2'b00, 1'b0, "R8 code 00 ignored");
      push_exp(cyc + 2, V_RUN, 2'b00, 1'b0, "R8 code 00 still run");
      lp_req = 1'b1; lp_code = 2'b00;
      @(negedge clk); lp_req = 1'b0;
      @(negedge clk);

      wake_base = 16'd3;
      round_trip(2'b01, 1'b0, 3, "sleep irq");
      round_trip(2'b01, 1'b1, 3, "sleep pin");
      round_trip(2'b10, 1'b0, 24, "deep irq");
      round_trip(2'b11, 1'b1, 240, "off pin");

      wake_base = 16'd0;
      round_trip(2'b01, 1'b0, 1, "sleep base0");

      wake_base = 16'd1000;
      round_trip(2'b10, 1'b1, 8000, "deep wide R9");
      wake_base = 16'd100;
      round_trip(2'b11, 1'b1, 8000, "off wide R9");

      wake_base = 16'd3;
      latched_wake(1, 3, "same cycle as request");
      latched_wake(2, 3, "mid entry");
      latched_wake(3, 3, "last entry edge");

      repeat (4) @(negedge clk);
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R1 scoreboard: got %0d pending expected 0", q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule